// File: doc/BRIEF.md
# Keyed Hardware Watchdog with Timed Reset Output

This block is a hardware watchdog that starts out switched off. Software switches it on by writing a two-byte key to a single write-only register, and it can never switch it off again. While the watchdog runs, a counter advances once for each machine-cycle tick. Writing the same key again restarts the count. If the counter reaches its all-ones value before software writes the key, the block raises a one-clock chip reset request. It then drives a reset-out pin high for a fixed number of oscillator clocks and falls back to the switched-off state it had at power-up.

The counter keeps running while the CPU idles and freezes at its current value while the chip is powered down. The reset-out pulse is timed in clock cycles of the block's own clock, which runs at the oscillator rate. It does not depend on the machine-cycle tick.

Top module: `seqdog_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `wd_on`, `rst_req` and `rst_out` at 0, with the watchdog switched off and the key detector waiting for its first byte.
- R2: A write of 0x1E followed by a write of 0xE1 arms the watchdog. Cycles with no write may come between the two writes. `wd_on` reads 1 from the clock after the 0xE1 write, and the counter starts from 0.
- R3: Any byte other than 0xE1 written right after 0x1E breaks the key, and the detector goes back to waiting for 0x1E. A repeated 0x1E counts as a fresh first byte. A 0xE1 that does not follow 0x1E has no effect.
- R4: Once armed, `wd_on` stays 1 whatever bytes are written. It drops only on an overflow.
- R5: While armed, the 14-bit counter adds one on each clock edge where `mc_tick`=1 and `pdown`=0. On the edge after the counter holds 0x3FFF, `rst_req` goes high for exactly one clock and `wd_on` returns to 0.
- R6: A complete key written while armed clears the counter. After that write, with a tick on every clock, `rst_req` stays low for 16383 clocks and rises on the 16384th.
- R7: While `pdown`=1, the counter holds its value. `idle` has no effect on counting.
- R8: `rst_out` rises together with `rst_req` and stays high for exactly 96 clocks.
- R9: If a key is completed in the same cycle as an overflow, the refresh wins. No reset is issued and the watchdog stays armed with its counter cleared.
- R10: While `rst_out` is high, writes are ignored and the pulse cannot be retriggered. `wd_on` reads 0 during the pulse and after it, until a new key is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe for the key register |
| wr_data | input | 8 | Byte written to the key register |
| mc_tick | input | 1 | One-clock machine-cycle tick |
| idle | input | 1 | CPU idle flag (counting continues) |
| pdown | input | 1 | Power-down flag (counting frozen) |
| rst_req | output | 1 | One-clock chip reset request on overflow |
| rst_out | output | 1 | Reset-out pin, high for the timed pulse |
| wd_on | output | 1 | Watchdog armed status |

## Verification
A seeded random phase mixes key bytes, near-key bytes and arbitrary bytes, with random gaps between writes, random ticks and random idle and power-down flags. It is compared cycle by cycle with a bench model, which separates correct key tracking from detectors that accept broken or reordered keys. Three patterns are directed:
- Broken keys (0x1E, 0x55, 0xE1) and a doubled first byte, which separate a strict key detector from a loose one.
- A long power-down hold followed by a free run to overflow, which shows that the counter freezes rather than resets.
- A refresh timed onto the overflow cycle, and key writes during the reset pulse, which check that a refresh wins over the overflow and that the pulse cannot be retriggered.

// File: rtl/seqdog_pkg.sv
package seqdog_pkg;
  typedef enum logic {
    KEY_WAIT = 1'b0,
    KEY_HALF = 1'b1
  } key_st_t;
endpackage

// File: rtl/seqdog_keydet.sv
module seqdog_keydet
  import seqdog_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h1E,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       blocked,
  output logic       key_hit
);
  key_st_t st_q;

  // Key completes on the second byte only when the first was seen just before.
  always_comb key_hit = wr_en && !blocked && (st_q == KEY_HALF) && (wr_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst || blocked) begin
      st_q <= KEY_WAIT;
    end else if (wr_en) begin
      st_q <= (wr_data == KEY_FIRST) ? KEY_HALF : KEY_WAIT;
    end
  end
endmodule

// File: rtl/seqdog_counter.sv
module seqdog_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_hit,
  input  logic             mc_tick,
  input  logic             pdown,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // A refresh in the overflow cycle suppresses the reset.
  always_comb fire = en_q && (cnt_q == CNT_MAX) && !key_hit;

  always_ff @(posedge clk) begin
    if (rst || fire) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (key_hit) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (en_q && mc_tick && !pdown) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/seqdog_pulse.sv
module seqdog_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_q,
  output logic req_q
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] left_q;
  logic          start;

  always_comb start = fire && !pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      req_q   <= 1'b0;
      left_q  <= '0;
    end else begin
      req_q <= start;
      if (start) begin
        pulse_q <= 1'b1;
        left_q  <= PW'(PULSE_LEN - 1);
      end else if (pulse_q) begin
        if (left_q == '0) pulse_q <= 1'b0;
        else left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/seqdog_top.sv
module seqdog_top #(
  parameter int         CNT_W      = 14,
  parameter int         PULSE_LEN  = 96,
  parameter logic [7:0] KEY_FIRST  = 8'h1E,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       mc_tick,
  input  logic       idle,
  input  logic       pdown,
  output logic       rst_req,
  output logic       rst_out,
  output logic       wd_on
);
  logic             key_hit;
  logic             fire;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;
  logic             req_q;

  seqdog_keydet #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_key (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .blocked(pulse_q), .key_hit(key_hit)
  );

  seqdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .key_hit(key_hit), .mc_tick(mc_tick),
    .pdown(pdown), .en_q(en_q), .cnt_q(cnt_q), .fire(fire)
  );

  seqdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk(clk), .rst(rst), .fire(fire), .pulse_q(pulse_q), .req_q(req_q)
  );

  assign rst_req = req_q;
  assign rst_out = pulse_q;
  assign wd_on   = en_q;
endmodule

module seqdog_chk #(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 96
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             mc_tick,
  input logic             idle,
  input logic             pdown,
  input logic             rst_req,
  input logic             rst_out,
  input logic             wd_on,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !rst_out) run_len <= 0;
    else run_len <= run_len + 1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wd_on && !rst_out && !rst_req));

  assert_stay_armed_R4: assert property (@(posedge clk) disable iff (rst)
    wd_on |=> (wd_on || rst_req));

  assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_req_drops_on_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !wd_on);

  assert_pdown_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wd_on && pdown && !wr_en && cnt != CNT_MAX) |=> (cnt == $past(cnt)));

  assert_idle_counts_R7: assert property (@(posedge clk) disable iff (rst)
    (wd_on && idle && mc_tick && !pdown && !wr_en && cnt != CNT_MAX)
      |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_req_with_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> rst_out);

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_out && run_len == PULSE_LEN - 1) |=> !rst_out);

  assert_pulse_min_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_out && run_len < PULSE_LEN - 1) |=> rst_out);

  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (rst)
    (rst_out && !rst_req) |-> (!rst_req && !wd_on));
endmodule

bind seqdog_top seqdog_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .mc_tick(mc_tick), .idle(idle),
  .pdown(pdown), .rst_req(rst_req), .rst_out(rst_out), .wd_on(wd_on), .cnt(cnt_q)
);

// File: tb/seqdog_top_bench.sv
module seqdog_top_bench;
  localparam int CNT_W = 14;
  localparam int PL    = 96;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       mc_tick = 1'b0;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       rst_req, rst_out, wd_on;

  seqdog_top u_seqdog_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .mc_tick(mc_tick),
    .idle(idle), .pdown(pdown), .rst_req(rst_req), .rst_out(rst_out), .wd_on(wd_on)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit m_seen, m_en, m_req, m_out;
  int m_cnt, m_left;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit key_done(input bit w, input logic [7:0] d);
    return w && m_seen && d == 8'hE1 && !m_out;
  endfunction

  task automatic model_edge();
    bit kh, fire;
    kh   = key_done(wr_en, wr_data);
    fire = m_en && m_cnt == MAXC && !kh;
    if (m_out) m_seen = 1'b0;
    else if (wr_en) m_seen = (wr_data == 8'h1E);
    if (fire) begin m_en = 1'b0; m_cnt = 0; end
    else if (kh) begin m_en = 1'b1; m_cnt = 0; end
    else if (m_en && mc_tick && !pdown) m_cnt++;
    if (fire && !m_out) begin m_out = 1'b1; m_left = PL - 1; end
    else if (m_out) begin
      if (m_left == 0) m_out = 1'b0;
      else m_left--;
    end
    m_req = fire;
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit t, input bit i, input bit p);
    wr_en = w; wr_data = d; mc_tick = t; idle = i; pdown = p;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(wd_on == m_en, "R4 wd_on lockstep", wd_on, m_en);
    chk(rst_req == m_req, "R5 rst_req lockstep", rst_req, m_req);
    chk(rst_out == m_out, "R8 rst_out lockstep", rst_out, m_out);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    int hi_len;
    bit seen_req;
    seed = 7;
    void'($urandom(seed));
    m_seen = 0; m_en = 0; m_req = 0; m_out = 0; m_cnt = 0; m_left = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(wd_on == 0 && rst_req == 0 && rst_out == 0, "R1 reset outputs", {wd_on, rst_req, rst_out}, 0);

    // R3: broken key and lone second byte
    step(1, 8'h1E, 1, 0, 0); step(1, 8'h55, 1, 0, 0); step(1, 8'hE1, 1, 0, 0);
    chk(wd_on == 0, "R3 broken key ignored", wd_on, 0);
    step(1, 8'hE1, 0, 0, 0);
    chk(wd_on == 0, "R3 lone E1 ignored", wd_on, 0);

    // R2 and R3: doubled first byte, gap, then second byte
    step(1, 8'h1E, 0, 0, 0); step(1, 8'h1E, 0, 0, 0); step(0, 8'h00, 1, 0, 0);
    step(1, 8'hE1, 0, 0, 0);
    chk(wd_on == 1, "R2 key arms watchdog", wd_on, 1);

    // Random mix, compared in lockstep
    for (int k = 0; k < 3000; k++) begin
      int r;
      logic [7:0] b;
      r = $urandom_range(0, 9);
      b = (r < 3) ? 8'h1E : (r < 6) ? 8'hE1 : 8'($urandom);
      step($urandom_range(0, 1), b, $urandom_range(0, 9) < 6,
           $urandom_range(0, 1), $urandom_range(0, 4) == 0);
    end
    chk(wd_on == 1, "R4 stays armed under random writes", wd_on, 1);

    // R7: power-down freezes the count
    for (int k = 0; k < 20000; k++) step(0, 8'h00, 1, 0, 1);
    chk(wd_on == 1 && rst_req == 0, "R7 pdown holds count", wd_on, 1);

    // R5 and R7: idle keeps counting until overflow
    seen_req = 0;
    for (int k = 0; k < 17000 && !seen_req; k++) begin
      step(0, 8'h00, 1, 1, 0);
      if (rst_req) seen_req = 1;
    end
    chk(seen_req == 1, "R5 overflow raises rst_req", seen_req, 1);
    chk(wd_on == 0, "R5 overflow disarms", wd_on, 0);

    // R8 and R10: pulse width, writes ignored during the pulse
    hi_len = 1;
    step(1, 8'h1E, 1, 0, 0); if (rst_out) hi_len++;
    step(1, 8'hE1, 1, 0, 0); if (rst_out) hi_len++;
    chk(wd_on == 0, "R10 key during pulse ignored", wd_on, 0);
    for (int k = 0; k < 120; k++) begin
      step(0, 8'h00, 1, 0, 0);
      if (rst_out) hi_len++;
      chk(rst_req == 0, "R10 no retrigger", rst_req, 0);
    end
    chk(hi_len == PL, "R8 pulse length", hi_len, PL);
    chk(wd_on == 0, "R10 disarmed after pulse", wd_on, 0);

    // R9: refresh in the overflow cycle
    step(1, 8'h1E, 0, 0, 0); step(1, 8'hE1, 0, 0, 0);
    chk(wd_on == 1, "R10 re-arm after pulse", wd_on, 1);
    while (m_cnt < MAXC - 1) step(0, 8'h00, 1, 0, 0);
    step(1, 8'h1E, 1, 0, 0);
    chk(m_cnt == MAXC, "R9 setup at terminal count", m_cnt, MAXC);
    step(1, 8'hE1, 1, 0, 0);
    chk(rst_req == 0 && wd_on == 1, "R9 refresh wins", rst_req, 0);

    // R6: full period after a refresh
    seen_req = 0;
    for (int k = 0; k < MAXC; k++) begin
      step(0, 8'h00, 1, 0, 0);
      if (rst_req) seen_req = 1;
    end
    chk(seen_req == 0, "R6 no reset before full period", seen_req, 0);
    step(0, 8'h00, 1, 0, 0);
    chk(rst_req == 1, "R6 reset at full period", rst_req, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule